// File: doc/BRIEF.md
# Two-Level Line Invalidate Controller

This block carries an address-targeted invalidate through two cache levels. A request from the core side names one line. The first-level agent drops its own copy of that line at once, whether or not the line was present. After a fixed issue delay it places a control message on the request network. The message carries only the line address and the index of the second-level slice that owns it. That index is taken from a parameterised field of the line address, given by a low bit position and a width.

Each second-level slice watches the request network for messages addressed to it. It clears the line whatever its prior state and, after a fixed response delay, returns an acknowledgement for that address. When the acknowledgement reaches the first-level agent it raises a one-cycle completion for the address, and the core may then issue the next invalidate. Only one invalidate is in flight at a time.

Storage at both levels is reduced to one valid bit per line. Fill ports set these bits and probe ports read them. A response network input lets other agents' traffic reach the first-level agent. Any response that is not the expected acknowledgement raises a sticky error flag.

Top module: `line_inval_ctrl`

## Requirements
- R1: After synchronous active-low reset, every line at both levels reads invalid, `core_req_ready` is 1, and `reqnet_valid`, `cmpl_valid` and `err_flag` are 0.
- R2: An accepted invalidate to a line that is valid in the first level reads invalid at the first-level probe in the cycle after acceptance, and an invalidate message is still issued.
- R3: An accepted invalidate to a line that is already invalid in the first level leaves it invalid and still issues exactly one invalidate message.
- R4: The invalidate message is a one-cycle `reqnet_valid` pulse that rises ISSUE_LAT cycles after the acceptance edge. It carries the line address, and `reqnet_slice` equals the line address bits [SEL_LO +: SEL_BITS].
- R5: The addressed second-level slice clears the line one cycle after the message, whether the line was valid or invalid, and leaves every other second-level line unchanged.
- R6: `cmpl_valid` pulses for exactly one cycle, ISSUE_LAT+RESP_LAT+2 cycles after the acceptance edge, with `cmpl_addr` equal to the invalidated line. `core_req_ready` is 1 again in that cycle.
- R7: `core_req_ready` is 0 from the cycle after acceptance until completion. A request presented while it is 0 is ignored: it clears no line and issues no message.
- R8: `err_flag` is set, and stays set until reset, when a response arrives whose type is not the acknowledgement code 2'b01. It is also set when an acknowledgement arrives with no matching invalidate outstanding.
- R9: When a first-level fill and an accepted invalidate name the same line in the same cycle, the line ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req_valid | input | 1 | Core invalidate request |
| core_req_addr | input | LINE_AW | Line address of the request |
| core_req_ready | output | 1 | Agent can accept a request |
| l1_fill_valid | input | 1 | Set a first-level valid bit |
| l1_fill_addr | input | LINE_AW | Line to fill at first level |
| l2_fill_valid | input | 1 | Set a second-level valid bit in the owning slice |
| l2_fill_addr | input | LINE_AW | Line to fill at second level |
| l1_probe_addr | input | LINE_AW | First-level line to read |
| l1_probe_hit | output | 1 | Probed first-level line is valid |
| l2_probe_addr | input | LINE_AW | Second-level line to read |
| l2_probe_hit | output | 1 | Probed line is valid in its owning slice |
| reqnet_valid | output | 1 | Invalidate message on the request network |
| reqnet_addr | output | LINE_AW | Line address of the message |
| reqnet_slice | output | SEL_BITS | Destination slice of the message |
| rsp_in_valid | input | 1 | Response from another agent |
| rsp_in_type | input | 2 | Response type code |
| rsp_in_addr | input | LINE_AW | Line address of the response |
| cmpl_valid | output | 1 | Invalidate completed |
| cmpl_addr | output | LINE_AW | Line whose invalidate completed |
| err_flag | output | 1 | Sticky unexpected-response flag |

## Verification
The main function is driven through a table of eight lines. The table covers all four combinations of prior first- and second-level validity and every slice index. This separates the clearing of a present copy from the forwarding of an absent one, at each level and for each slice. For every entry, the message and completion timing is measured against the two latencies. A neighbouring line in the same slice is checked as well, which tells a line-precise clear from a slice-wide one. Directed cases add a fill colliding with an invalidate, requests pushed while busy, foreign and unmatched responses, and reset with lines present.

// File: rtl/line_inval_pkg.sv
// Shared types for the two-level line invalidate controller.
// Assumes a 2-bit response type field on the response network.
package line_inval_pkg;
    typedef enum logic [1:0] {
        AG_IDLE  = 2'd0,
        AG_ISSUE = 2'd1,
        AG_WAIT  = 2'd2
    } agent_state_e;

    localparam logic [1:0] RSP_INV_ACK = 2'b01;
endpackage

// File: rtl/l1_inval_agent.sv
// First-level invalidate agent: holds per-line valid bits, accepts one
// invalidate at a time, clears the local line, issues the network message
// after ISSUE_LAT cycles and completes on a matching acknowledgement.
// Assumes ISSUE_LAT >= 1 and that the slice field lies inside the address.
module l1_inval_agent
    import line_inval_pkg::*;
#(
    parameter int LINE_AW   = 6,
    parameter int SEL_LO    = 0,
    parameter int SEL_BITS  = 2,
    parameter int ISSUE_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LINE_AW-1:0]  req_addr,
    output logic                req_ready,
    input  logic                fill_valid,
    input  logic [LINE_AW-1:0]  fill_addr,
    input  logic [LINE_AW-1:0]  probe_addr,
    output logic                probe_hit,
    output logic                net_valid,
    output logic [LINE_AW-1:0]  net_addr,
    output logic [SEL_BITS-1:0] net_slice,
    input  logic                rsp_valid,
    input  logic [1:0]          rsp_type,
    input  logic [LINE_AW-1:0]  rsp_addr,
    output logic                cmpl_valid,
    output logic [LINE_AW-1:0]  cmpl_addr,
    output logic                err
);
    localparam int LINES = 1 << LINE_AW;
    localparam int IW    = $clog2(ISSUE_LAT + 1);

    logic [LINES-1:0]   vld_q;
    agent_state_e       state_q;
    logic [IW-1:0]      cnt_q;
    logic [LINE_AW-1:0] pend_q;
    logic               accept;
    logic               rsp_match;

    assign req_ready = (state_q == AG_IDLE);
    assign accept    = req_valid && req_ready;
    assign probe_hit = vld_q[probe_addr];
    assign net_addr  = pend_q;
    assign net_slice = pend_q[SEL_LO +: SEL_BITS];
    assign rsp_match = rsp_valid && (rsp_type == RSP_INV_ACK) &&
                       (state_q == AG_WAIT) && (rsp_addr == pend_q);

    // Valid bits: fills set, an accepted invalidate clears (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (fill_valid) vld_q[fill_addr] <= 1'b1;
            if (accept)     vld_q[req_addr]  <= 1'b0;
        end
    end

    // Sequencer: accept, count issue delay, emit message, await ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= AG_IDLE;
            cnt_q      <= '0;
            pend_q     <= '0;
            net_valid  <= 1'b0;
            cmpl_valid <= 1'b0;
            cmpl_addr  <= '0;
        end else begin
            net_valid  <= 1'b0;
            cmpl_valid <= 1'b0;
            case (state_q)
                AG_IDLE: begin
                    if (accept) begin
                        pend_q  <= req_addr;
                        cnt_q   <= IW'(ISSUE_LAT);
                        state_q <= AG_ISSUE;
                    end
                end
                AG_ISSUE: begin
                    if (cnt_q == IW'(1)) begin
                        net_valid <= 1'b1;
                        state_q   <= AG_WAIT;
                    end else begin
                        cnt_q <= cnt_q - IW'(1);
                    end
                end
                AG_WAIT: begin
                    if (rsp_match) begin
                        cmpl_valid <= 1'b1;
                        cmpl_addr  <= pend_q;
                        state_q    <= AG_IDLE;
                    end
                end
                default: state_q <= AG_IDLE;
            endcase
        end
    end

    // Sticky error on any response that is not the awaited acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err <= 1'b0;
        else if (rsp_valid && !rsp_match) err <= 1'b1;
    end
endmodule

// File: rtl/l2_inval_slice.sv
// Second-level slice: per-line valid bits for the lines it owns. A message
// addressed to this slice clears the line regardless of its state and
// returns a one-cycle acknowledgement RESP_LAT cycles later.
// Assumes RESP_LAT >= 1 and at most one message in flight.
module l2_inval_slice #(
    parameter int LINE_AW  = 6,
    parameter int SEL_LO   = 0,
    parameter int SEL_BITS = 2,
    parameter int SLICE_ID = 0,
    parameter int RESP_LAT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                net_valid,
    input  logic [LINE_AW-1:0]  net_addr,
    input  logic [SEL_BITS-1:0] net_slice,
    input  logic                fill_valid,
    input  logic [LINE_AW-1:0]  fill_addr,
    input  logic [LINE_AW-1:0]  probe_addr,
    output logic                probe_hit,
    output logic                ack_valid,
    output logic [LINE_AW-1:0]  ack_addr
);
    localparam int LINES = 1 << LINE_AW;
    localparam int RW    = $clog2(RESP_LAT + 1);

    logic [LINES-1:0] vld_q;
    logic [RW-1:0]    cnt_q;
    logic             busy_q;
    logic             msg_hit;
    logic             fill_hit;

    assign msg_hit   = net_valid && (net_slice == SEL_BITS'(SLICE_ID));
    assign fill_hit  = fill_valid &&
                       (fill_addr[SEL_LO +: SEL_BITS] == SEL_BITS'(SLICE_ID));
    assign probe_hit = vld_q[probe_addr];

    // Valid bits: owned fills set, an addressed message clears (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (fill_hit) vld_q[fill_addr] <= 1'b1;
            if (msg_hit)  vld_q[net_addr]  <= 1'b0;
        end
    end

    // Response timer: capture the requester's line and acknowledge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            ack_valid <= 1'b0;
            ack_addr  <= '0;
        end else begin
            ack_valid <= 1'b0;
            if (msg_hit) begin
                busy_q   <= 1'b1;
                cnt_q    <= RW'(RESP_LAT);
                ack_addr <= net_addr;
            end else if (busy_q) begin
                if (cnt_q == RW'(1)) begin
                    ack_valid <= 1'b1;
                    busy_q    <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/line_inval_ctrl.sv
// Top of the two-level line invalidate controller: one first-level agent,
// 2**SEL_BITS second-level slices on the request network, and a response
// merge in which slice acknowledgements take precedence over external traffic.
// Assumes the core waits for completion before the next invalidate.
module line_inval_ctrl
    import line_inval_pkg::*;
#(
    parameter int LINE_AW   = 6,
    parameter int SEL_LO    = 0,
    parameter int SEL_BITS  = 2,
    parameter int ISSUE_LAT = 2,
    parameter int RESP_LAT  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_req_valid,
    input  logic [LINE_AW-1:0]  core_req_addr,
    output logic                core_req_ready,
    input  logic                l1_fill_valid,
    input  logic [LINE_AW-1:0]  l1_fill_addr,
    input  logic                l2_fill_valid,
    input  logic [LINE_AW-1:0]  l2_fill_addr,
    input  logic [LINE_AW-1:0]  l1_probe_addr,
    output logic                l1_probe_hit,
    input  logic [LINE_AW-1:0]  l2_probe_addr,
    output logic                l2_probe_hit,
    output logic                reqnet_valid,
    output logic [LINE_AW-1:0]  reqnet_addr,
    output logic [SEL_BITS-1:0] reqnet_slice,
    input  logic                rsp_in_valid,
    input  logic [1:0]          rsp_in_type,
    input  logic [LINE_AW-1:0]  rsp_in_addr,
    output logic                cmpl_valid,
    output logic [LINE_AW-1:0]  cmpl_addr,
    output logic                err_flag
);
    localparam int NUM_SLICES = 1 << SEL_BITS;

    logic [NUM_SLICES-1:0] ack_v;
    logic [LINE_AW-1:0]    ack_a [NUM_SLICES];
    logic [NUM_SLICES-1:0] slice_hit;
    logic                  int_v;
    logic [LINE_AW-1:0]    int_a;
    logic                  rsp_v;
    logic [1:0]            rsp_t;
    logic [LINE_AW-1:0]    rsp_a;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        l2_inval_slice #(
            .LINE_AW (LINE_AW),
            .SEL_LO  (SEL_LO),
            .SEL_BITS(SEL_BITS),
            .SLICE_ID(s),
            .RESP_LAT(RESP_LAT)
        ) i_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .net_valid (reqnet_valid),
            .net_addr  (reqnet_addr),
            .net_slice (reqnet_slice),
            .fill_valid(l2_fill_valid),
            .fill_addr (l2_fill_addr),
            .probe_addr(l2_probe_addr),
            .probe_hit (slice_hit[s]),
            .ack_valid (ack_v[s]),
            .ack_addr  (ack_a[s])
        );
    end

    // Gather the (at most one) slice acknowledgement onto the return path.
    always_comb begin
        int_v = 1'b0;
        int_a = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            int_v = int_v | ack_v[s];
            if (ack_v[s]) int_a = int_a | ack_a[s];
        end
    end

    // Merge slice acknowledgements with external responses; slices win.
    always_comb begin
        rsp_v = int_v | rsp_in_valid;
        rsp_t = int_v ? RSP_INV_ACK : rsp_in_type;
        rsp_a = int_v ? int_a : rsp_in_addr;
    end

    assign l2_probe_hit = slice_hit[l2_probe_addr[SEL_LO +: SEL_BITS]];

    l1_inval_agent #(
        .LINE_AW  (LINE_AW),
        .SEL_LO   (SEL_LO),
        .SEL_BITS (SEL_BITS),
        .ISSUE_LAT(ISSUE_LAT)
    ) i_agent (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (core_req_valid),
        .req_addr  (core_req_addr),
        .req_ready (core_req_ready),
        .fill_valid(l1_fill_valid),
        .fill_addr (l1_fill_addr),
        .probe_addr(l1_probe_addr),
        .probe_hit (l1_probe_hit),
        .net_valid (reqnet_valid),
        .net_addr  (reqnet_addr),
        .net_slice (reqnet_slice),
        .rsp_valid (rsp_v),
        .rsp_type  (rsp_t),
        .rsp_addr  (rsp_a),
        .cmpl_valid(cmpl_valid),
        .cmpl_addr (cmpl_addr),
        .err       (err_flag)
    );
endmodule

// File: rtl/line_inval_ctrl_chk.sv
// Property checker for line_inval_ctrl, attached by bind below.
// Assumes it observes only top-level ports.
module line_inval_ctrl_chk #(
    parameter int LINE_AW  = 6,
    parameter int SEL_LO   = 0,
    parameter int SEL_BITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                core_req_valid,
    input logic [LINE_AW-1:0]  core_req_addr,
    input logic                core_req_ready,
    input logic [LINE_AW-1:0]  l1_probe_addr,
    input logic                l1_probe_hit,
    input logic                reqnet_valid,
    input logic [LINE_AW-1:0]  reqnet_addr,
    input logic [SEL_BITS-1:0] reqnet_slice,
    input logic                cmpl_valid,
    input logic                err_flag
);
    logic rst_seen_q = 1'b0;

    // Remember that reset was applied at the last rising edge.
    always @(posedge clk) rst_seen_q <= !rst_n;

    // Check the reset state half a cycle after a reset edge.
    always @(negedge clk) begin
        if (rst_seen_q)
            assert_reset_state_R1: assert (core_req_ready && !reqnet_valid &&
                                           !cmpl_valid && !err_flag)
                else $error("reset state wrong");
    end

    assert_line_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && core_req_ready) |=>
        (!$stable(l1_probe_addr) || l1_probe_addr != $past(core_req_addr) ||
         !l1_probe_hit));

    assert_msg_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reqnet_valid |-> (reqnet_slice == reqnet_addr[SEL_LO +: SEL_BITS]));

    assert_msg_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reqnet_valid |=> !reqnet_valid);

    assert_cmpl_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> !cmpl_valid);

    assert_cmpl_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |-> core_req_ready);

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && core_req_ready) |=> !core_req_ready);

    assert_msg_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reqnet_valid |-> !core_req_ready);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind line_inval_ctrl line_inval_ctrl_chk #(
    .LINE_AW (LINE_AW),
    .SEL_LO  (SEL_LO),
    .SEL_BITS(SEL_BITS)
) i_line_inval_ctrl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_req_valid(core_req_valid),
    .core_req_addr (core_req_addr),
    .core_req_ready(core_req_ready),
    .l1_probe_addr (l1_probe_addr),
    .l1_probe_hit  (l1_probe_hit),
    .reqnet_valid  (reqnet_valid),
    .reqnet_addr   (reqnet_addr),
    .reqnet_slice  (reqnet_slice),
    .cmpl_valid    (cmpl_valid),
    .err_flag      (err_flag)
);

// File: tb/test_line_inval_ctrl.sv
module test_line_inval_ctrl;
    localparam int AW = 6;
    localparam int SL = 0;
    localparam int SB = 2;
    localparam int IL = 2;
    localparam int RL = 3;
    localparam int NV = 8;

    // Vector: {l1 prefill, l2 prefill, line address}
    localparam logic [AW+1:0] VEC [NV] = '{
        {1'b1, 1'b1, 6'h05}, {1'b0, 1'b1, 6'h0A}, {1'b1, 1'b0, 6'h13},
        {1'b0, 1'b0, 6'h3F}, {1'b1, 1'b1, 6'h00}, {1'b0, 1'b0, 6'h22},
        {1'b1, 1'b1, 6'h2E}, {1'b0, 1'b1, 6'h31}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req_valid = 1'b0;
    logic [AW-1:0] core_req_addr = '0;
    logic          core_req_ready;
    logic          l1_fill_valid = 1'b0;
    logic [AW-1:0] l1_fill_addr = '0;
    logic          l2_fill_valid = 1'b0;
    logic [AW-1:0] l2_fill_addr = '0;
    logic [AW-1:0] l1_probe_addr = '0;
    logic          l1_probe_hit;
    logic [AW-1:0] l2_probe_addr = '0;
    logic          l2_probe_hit;
    logic          reqnet_valid;
    logic [AW-1:0] reqnet_addr;
    logic [SB-1:0] reqnet_slice;
    logic          rsp_in_valid = 1'b0;
    logic [1:0]    rsp_in_type = '0;
    logic [AW-1:0] rsp_in_addr = '0;
    logic          cmpl_valid;
    logic [AW-1:0] cmpl_addr;
    logic          err_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_inval_ctrl #(.LINE_AW(AW), .SEL_LO(SL), .SEL_BITS(SB),
                      .ISSUE_LAT(IL), .RESP_LAT(RL)) i_line_inval_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(core_req_valid), .core_req_addr(core_req_addr),
        .core_req_ready(core_req_ready),
        .l1_fill_valid(l1_fill_valid), .l1_fill_addr(l1_fill_addr),
        .l2_fill_valid(l2_fill_valid), .l2_fill_addr(l2_fill_addr),
        .l1_probe_addr(l1_probe_addr), .l1_probe_hit(l1_probe_hit),
        .l2_probe_addr(l2_probe_addr), .l2_probe_hit(l2_probe_hit),
        .reqnet_valid(reqnet_valid), .reqnet_addr(reqnet_addr),
        .reqnet_slice(reqnet_slice),
        .rsp_in_valid(rsp_in_valid), .rsp_in_type(rsp_in_type),
        .rsp_in_addr(rsp_in_addr),
        .cmpl_valid(cmpl_valid), .cmpl_addr(cmpl_addr), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input logic [AW-1:0] a, input bit f1, input bit f2);
        l1_fill_valid = f1; l1_fill_addr = a;
        l2_fill_valid = f2; l2_fill_addr = a;
        @(negedge clk);
        l1_fill_valid = 1'b0; l2_fill_valid = 1'b0;
    endtask

    // Issue one invalidate and measure message and completion timing.
    task automatic run_inval(input logic [AW-1:0] a, input bit p1, input bit p2);
        logic [AW-1:0] nb;
        int msg_at, cmpl_at, msg_n, cmpl_n;
        nb = a ^ 6'h04;
        if (p1 || p2) fill(a, p1, p2);
        fill(nb, 1'b0, 1'b1);
        l1_probe_addr = a; l2_probe_addr = a; #1;
        chk(l1_probe_hit == p1, "R2 setup l1", l1_probe_hit, p1);
        chk(l2_probe_hit == p2, "R5 setup l2", l2_probe_hit, p2);
        core_req_valid = 1'b1; core_req_addr = a;
        @(negedge clk);
        core_req_valid = 1'b0;
        chk(!l1_probe_hit, p1 ? "R2 l1 cleared" : "R3 l1 stays invalid", l1_probe_hit, 0);
        chk(!core_req_ready, "R7 busy", core_req_ready, 0);
        msg_at = -1; cmpl_at = -1; msg_n = 0; cmpl_n = 0;
        for (int i = 0; i < 20; i++) begin
            if (i > 0) @(negedge clk);
            if (reqnet_valid) begin
                msg_n++;
                if (msg_at < 0) msg_at = i;
                chk(reqnet_addr == a, "R4 msg addr", reqnet_addr, a);
                chk(reqnet_slice == a[SL +: SB], "R4 msg slice", reqnet_slice, a[SL +: SB]);
            end
            if (i == IL + 1)
                chk(!l2_probe_hit, "R5 l2 cleared", l2_probe_hit, 0);
            if (cmpl_valid) begin
                cmpl_n++;
                if (cmpl_at < 0) cmpl_at = i;
                chk(cmpl_addr == a, "R6 cmpl addr", cmpl_addr, a);
                chk(core_req_ready, "R6 ready at cmpl", core_req_ready, 1);
            end
        end
        chk(msg_n == 1, "R3 one msg", msg_n, 1);
        chk(msg_at == IL, "R4 msg timing", msg_at, IL);
        chk(cmpl_n == 1, "R6 one cmpl", cmpl_n, 1);
        chk(cmpl_at == IL + RL + 2, "R6 cmpl timing", cmpl_at, IL + RL + 2);
        l2_probe_addr = nb; #1;
        chk(l2_probe_hit, "R5 neighbour kept", l2_probe_hit, 1);
        chk(!err_flag, "R8 no error", err_flag, 0);
    endtask

    initial begin
        do_reset();
        #1;
        // R1 reset state
        chk(core_req_ready && !reqnet_valid && !cmpl_valid && !err_flag,
            "R1 outputs", {core_req_ready, reqnet_valid, cmpl_valid, err_flag}, 8);
        l1_probe_addr = 6'h05; l2_probe_addr = 6'h05; #1;
        chk(!l1_probe_hit && !l2_probe_hit, "R1 lines invalid",
            {l1_probe_hit, l2_probe_hit}, 0);
        @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_inval(VEC[v][AW-1:0], VEC[v][AW+1], VEC[v][AW]);

        // R7: requests while busy are ignored
        fill(6'h09, 1'b1, 1'b0);
        core_req_valid = 1'b1; core_req_addr = 6'h14;
        @(negedge clk);
        core_req_addr = 6'h09;
        begin
            int msgs = 0;
            for (int i = 0; i < 20; i++) begin
                if (i > 0) @(negedge clk);
                if (i == 3) core_req_valid = 1'b0;
                if (reqnet_valid) msgs++;
            end
            core_req_valid = 1'b0;
            chk(msgs == 1, "R7 no extra msg", msgs, 1);
        end
        l1_probe_addr = 6'h09; #1;
        chk(l1_probe_hit, "R7 busy request ignored", l1_probe_hit, 1);
        repeat (12) @(negedge clk);

        // R9: fill and invalidate of the same line in one cycle
        l1_fill_valid = 1'b1; l1_fill_addr = 6'h1C;
        core_req_valid = 1'b1; core_req_addr = 6'h1C;
        @(negedge clk);
        l1_fill_valid = 1'b0; core_req_valid = 1'b0;
        l1_probe_addr = 6'h1C; #1;
        chk(!l1_probe_hit, "R9 invalidate wins", l1_probe_hit, 0);
        repeat (15) @(negedge clk);

        // R8: foreign response type
        rsp_in_valid = 1'b1; rsp_in_type = 2'b10; rsp_in_addr = 6'h01;
        @(negedge clk);
        rsp_in_valid = 1'b0;
        chk(err_flag, "R8 foreign type", err_flag, 1);
        repeat (3) @(negedge clk);
        chk(err_flag, "R8 sticky", err_flag, 1);

        // R1: reset clears lines and error
        fill(6'h2A, 1'b1, 1'b1);
        do_reset(); #1;
        l1_probe_addr = 6'h2A; l2_probe_addr = 6'h2A; #1;
        chk(!l1_probe_hit && !l2_probe_hit && !err_flag, "R1 reset clears",
            {l1_probe_hit, l2_probe_hit, err_flag}, 0);
        @(negedge clk);

        // R8: acknowledgement with nothing outstanding
        rsp_in_valid = 1'b1; rsp_in_type = 2'b01; rsp_in_addr = 6'h07;
        @(negedge clk);
        rsp_in_valid = 1'b0;
        chk(err_flag, "R8 unmatched ack", err_flag, 1);
        chk(!cmpl_valid, "R8 no cmpl", cmpl_valid, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule